// File: doc/BRIEF.md
# Wrap-Around Product Term Sharing Array

This block routes a bank of product terms, arranged as clusters of five, onto one sum-of-products output per macrocell slot. Every output is set up by static configuration: it either takes its own cluster straight through a bypass path, or it ORs a contiguous run of one to seven clusters that begins at a chosen start cluster. A run that passes the last cluster continues at cluster 0, so a single function can reach up to 35 product terms from anywhere in the array.

A cluster may feed only one output at a time. When the configuration gives a cluster to two outputs, the block still forms every OR and raises a single configuration error flag. The OR network is purely combinational. A parameter selects an optional register stage on the outputs, which is present by default.

Top module: `pterm_share_array`

## Requirements
- R1: Cluster c is formed by product terms 5c+4 down to 5c of `pTerms`. Each output is the OR of all product terms in every cluster that the output covers, and terms in clusters it does not cover have no effect on it.
- R2: For output o with bypass clear, the 5-bit field `cfgStart[5o+4:5o]` is the start cluster and the 3-bit field `cfgCount[3o+2:3o]` is the count (1 to 7). The output covers clusters start through start+count-1, taken modulo 32.
- R3: An output with count 0 and bypass clear drives 0 whatever its start field and the product terms are.
- R4: When `cfgBypass[o]` is 1, output o covers only cluster o. Its start and count fields are ignored.
- R5: With count 7, an output covers 35 product terms, which is seven clusters. Both the first term of the first cluster and the last term of the seventh cluster reach it, and the next cluster does not.
- R6: `cfgError` is 1 when some cluster is covered by two or more outputs, counting a bypass as coverage of the output's own cluster. It is 0 otherwise.
- R7: With the output register present, `sumOut` and `cfgError` show the result of the inputs one rising clock edge after those inputs are applied. While `rstN` is low, both outputs are 0.
- R8: A run that passes cluster 31 wraps to cluster 0. Start 30 with count 4 covers clusters 30, 31, 0 and 1, and does not cover cluster 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rstN | input | 1 | Active-low synchronous reset of the output register |
| pTerms | input | 160 | Product terms, five per cluster |
| cfgStart | input | 160 | Start cluster per output, 5 bits each |
| cfgCount | input | 96 | Cluster count per output, 3 bits each |
| cfgBypass | input | 32 | Bypass select per output |
| sumOut | output | 32 | One sum-of-products result per macrocell |
| cfgError | output | 1 | A cluster is covered by more than one output |

## Verification
The hardest case to reach from the ports is a full, legal configuration in which runs of mixed lengths wrap past cluster 31, bypassed outputs sit beside shared runs, and nothing overlaps. The bench reaches it by cutting the ring into random segments that start at a random cluster. It hands each segment to an unused output, sometimes as a bypass, and leaves some segments unowned. It then compares every output with a model built from the configuration under random product terms. Directed vectors cover single-term hits at run edges, and deliberate overlaps, including one that arises only through the wrap, cover the error flag.

// File: rtl/pterm_share_pkg.sv
package pterm_share_pkg;
  // Default geometry of the sharing array
  localparam int DEF_CLUSTERS = 32;
  localparam int DEF_TERMS_PER_CLUSTER = 5;
  localparam int DEF_MAX_SPAN = 7;

  // Distance walked forward from start to reach cluster idx, modulo the ring size
  function automatic int ringOffset(input int idx, input int start, input int ringSize);
    return (idx + ringSize - (start % ringSize)) % ringSize;
  endfunction
endpackage

// File: rtl/pterm_share_ctrl.sv
module pterm_share_ctrl #(
  parameter int NUM_CLUSTERS = 32,
  parameter int MAX_SPAN = 7,
  parameter int IDX_W = 5,
  parameter int CNT_W = 3
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [NUM_CLUSTERS*IDX_W-1:0]     cfgStart,
  input  logic [NUM_CLUSTERS*CNT_W-1:0]     cfgCount,
  input  logic [NUM_CLUSTERS-1:0]           cfgBypass,
  output logic [NUM_CLUSTERS-1:0][NUM_CLUSTERS-1:0] selMask,
  output logic                              conflict
);
  import pterm_share_pkg::*;

  localparam int CLAIM_W = $clog2(NUM_CLUSTERS + 1);

  logic [NUM_CLUSTERS-1:0][CLAIM_W-1:0] claimCount;
  logic [NUM_CLUSTERS-1:0] overClaimed;

  // Per-output cluster selection
  always_comb begin
    for (int o = 0; o < NUM_CLUSTERS; o++) begin
      int startIdx;
      int span;
      startIdx = int'(cfgStart[o*IDX_W +: IDX_W]);
      span = int'(cfgCount[o*CNT_W +: CNT_W]);
      if (span > MAX_SPAN) span = MAX_SPAN;
      for (int c = 0; c < NUM_CLUSTERS; c++) begin
        if (cfgBypass[o]) selMask[o][c] = (c == o);
        else selMask[o][c] = (ringOffset(c, startIdx, NUM_CLUSTERS) < span);
      end
    end
  end

  // Count how many outputs claim each cluster
  always_comb begin
    for (int c = 0; c < NUM_CLUSTERS; c++) begin
      claimCount[c] = '0;
      for (int o = 0; o < NUM_CLUSTERS; o++)
        claimCount[c] = claimCount[c] + CLAIM_W'(selMask[o][c]);
      overClaimed[c] = (claimCount[c] > CLAIM_W'(1));
    end
  end

  assign conflict = |overClaimed;

  generate
    for (genvar o = 0; o < NUM_CLUSTERS; o++) begin : g_spanChk
      // R5
      span_limit_chk: assert property (@(posedge clk) disable iff (!rstN)
        $countones(selMask[o]) <= MAX_SPAN);
      // R4
      bypass_single_chk: assert property (@(posedge clk) disable iff (!rstN)
        cfgBypass[o] |-> ($countones(selMask[o]) == 1 && selMask[o][o]));
    end
  endgenerate
endmodule

// File: rtl/pterm_share_datapath.sv
module pterm_share_datapath #(
  parameter int NUM_CLUSTERS = 32,
  parameter int TERMS_PER_CLUSTER = 5
) (
  input  logic                                      clk,
  input  logic                                      rstN,
  input  logic [NUM_CLUSTERS*TERMS_PER_CLUSTER-1:0] pTerms,
  input  logic [NUM_CLUSTERS-1:0][NUM_CLUSTERS-1:0] selMask,
  output logic [NUM_CLUSTERS-1:0]                   rawSum
);
  logic [NUM_CLUSTERS-1:0] clusterOr;

  generate
    for (genvar c = 0; c < NUM_CLUSTERS; c++) begin : g_cluster
      assign clusterOr[c] = |pTerms[c*TERMS_PER_CLUSTER +: TERMS_PER_CLUSTER];
    end
    for (genvar o = 0; o < NUM_CLUSTERS; o++) begin : g_out
      assign rawSum[o] = |(selMask[o] & clusterOr);
      // R3
      empty_out_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
        (selMask[o] == '0) |-> !rawSum[o]);
    end
  endgenerate
endmodule

// File: rtl/pterm_share_outreg.sv
module pterm_share_outreg #(
  parameter int WIDTH = 33,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] qOut
);
  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rstN) qOut <= '0;
        else qOut <= dIn;
      end
      // R7
      reg_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
        $past(rstN) |-> (qOut == $past(dIn)));
    end else begin : g_wire
      assign qOut = dIn;
    end
  endgenerate
endmodule

// File: rtl/pterm_share_array.sv
module pterm_share_array #(
  parameter int NUM_CLUSTERS = pterm_share_pkg::DEF_CLUSTERS,
  parameter int TERMS_PER_CLUSTER = pterm_share_pkg::DEF_TERMS_PER_CLUSTER,
  parameter int MAX_SPAN = pterm_share_pkg::DEF_MAX_SPAN,
  parameter bit REG_OUT = 1'b1,
  localparam int IDX_W = $clog2(NUM_CLUSTERS),
  localparam int CNT_W = $clog2(MAX_SPAN + 1),
  localparam int TERM_W = NUM_CLUSTERS * TERMS_PER_CLUSTER
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [TERM_W-1:0]             pTerms,
  input  logic [NUM_CLUSTERS*IDX_W-1:0] cfgStart,
  input  logic [NUM_CLUSTERS*CNT_W-1:0] cfgCount,
  input  logic [NUM_CLUSTERS-1:0]       cfgBypass,
  output logic [NUM_CLUSTERS-1:0]       sumOut,
  output logic                          cfgError
);
  logic [NUM_CLUSTERS-1:0][NUM_CLUSTERS-1:0] selMask;
  logic                    conflict;
  logic [NUM_CLUSTERS-1:0] rawSum;

  pterm_share_ctrl #(
    .NUM_CLUSTERS(NUM_CLUSTERS), .MAX_SPAN(MAX_SPAN), .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .cfgStart(cfgStart), .cfgCount(cfgCount),
    .cfgBypass(cfgBypass), .selMask(selMask), .conflict(conflict)
  );

  pterm_share_datapath #(
    .NUM_CLUSTERS(NUM_CLUSTERS), .TERMS_PER_CLUSTER(TERMS_PER_CLUSTER)
  ) dp_i (
    .clk(clk), .rstN(rstN), .pTerms(pTerms), .selMask(selMask), .rawSum(rawSum)
  );

  pterm_share_outreg #(
    .WIDTH(NUM_CLUSTERS + 1), .REG_OUT(REG_OUT)
  ) oreg_i (
    .clk(clk), .rstN(rstN), .dIn({conflict, rawSum}), .qOut({cfgError, sumOut})
  );

  generate
    for (genvar o = 0; o < NUM_CLUSTERS; o++) begin : g_bypChk
      // R4
      bypass_path_chk: assert property (@(posedge clk) disable iff (!rstN)
        cfgBypass[o] |-> (rawSum[o] == |pTerms[o*TERMS_PER_CLUSTER +: TERMS_PER_CLUSTER]));
    end
  endgenerate
endmodule

// File: tb/pterm_share_array_tb_top.sv
module pterm_share_array_tb_top;
  localparam int NC = 32;
  localparam int TPC = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NC*TPC-1:0] pTerms = '0;
  logic [NC*5-1:0] cfgStart = '0;
  logic [NC*3-1:0] cfgCount = '0;
  logic [NC-1:0] cfgBypass = '0;
  logic [NC-1:0] sumOut;
  logic cfgError;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  pterm_share_array dut_i (
    .clk(clk), .rstN(rstN), .pTerms(pTerms), .cfgStart(cfgStart),
    .cfgCount(cfgCount), .cfgBypass(cfgBypass), .sumOut(sumOut), .cfgError(cfgError)
  );

  typedef struct packed {
    logic [3:0] req;
    logic [7:0] outIdx;
    logic [7:0] start;
    logic [3:0] cnt;
    logic       byp;
    logic [7:0] hot;
    logic       expBit;
  } vec_t;

  // One output configured, one product term high
  localparam vec_t VECS[16] = '{
    '{4'd1, 8'd3,  8'd3,  4'd1, 1'b0, 8'd17,  1'b1}, // R1 own cluster term
    '{4'd1, 8'd3,  8'd3,  4'd1, 1'b0, 8'd20,  1'b0}, // R1 next cluster ignored
    '{4'd2, 8'd10, 8'd8,  4'd3, 1'b0, 8'd50,  1'b1}, // R2 inside run
    '{4'd2, 8'd10, 8'd8,  4'd3, 1'b0, 8'd55,  1'b0}, // R2 past end
    '{4'd2, 8'd10, 8'd8,  4'd3, 1'b0, 8'd39,  1'b0}, // R2 before start
    '{4'd2, 8'd10, 8'd8,  4'd3, 1'b0, 8'd40,  1'b1}, // R2 first term of start
    '{4'd8, 8'd0,  8'd30, 4'd4, 1'b0, 8'd5,   1'b1}, // R8 wrapped cluster 1
    '{4'd8, 8'd0,  8'd30, 4'd4, 1'b0, 8'd152, 1'b1}, // R8 cluster 30
    '{4'd8, 8'd0,  8'd30, 4'd4, 1'b0, 8'd10,  1'b0}, // R8 cluster 2 outside
    '{4'd5, 8'd20, 8'd13, 4'd7, 1'b0, 8'd65,  1'b1}, // R5 first of 35
    '{4'd5, 8'd20, 8'd13, 4'd7, 1'b0, 8'd99,  1'b1}, // R5 last of 35
    '{4'd5, 8'd20, 8'd13, 4'd7, 1'b0, 8'd100, 1'b0}, // R5 36th term
    '{4'd4, 8'd6,  8'd0,  4'd2, 1'b1, 8'd30,  1'b1}, // R4 own cluster
    '{4'd4, 8'd6,  8'd0,  4'd2, 1'b1, 8'd0,   1'b0}, // R4 start ignored
    '{4'd3, 8'd9,  8'd9,  4'd0, 1'b0, 8'd45,  1'b0}, // R3 empty output
    '{4'd3, 8'd9,  8'd2,  4'd0, 1'b0, 8'd12,  1'b0}  // R3 start ignored
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clearCfg();
    cfgStart = '0;
    cfgCount = '0;
    cfgBypass = '0;
    pTerms = '0;
  endtask

  task automatic setOut(input int o, input int st, input int cnt, input bit byp);
    cfgStart[o*5 +: 5] = 5'(st);
    cfgCount[o*3 +: 3] = 3'(cnt);
    cfgBypass[o] = byp;
  endtask

  // Model built from the requirements: walk each run cluster by cluster
  function automatic logic [NC-1:0] modelSum(input logic [NC*TPC-1:0] pt,
      input logic [NC*5-1:0] st, input logic [NC*3-1:0] ct, input logic [NC-1:0] by);
    logic [NC-1:0] r;
    r = '0;
    for (int o = 0; o < NC; o++) begin
      if (by[o]) r[o] = |pt[o*TPC +: TPC];
      else
        for (int k = 0; k < int'(ct[o*3 +: 3]); k++) begin
          int cl;
          cl = (int'(st[o*5 +: 5]) + k) % NC;
          if (|pt[cl*TPC +: TPC]) r[o] = 1'b1;
        end
    end
    return r;
  endfunction

  // Apply at a falling edge, result visible after the next rising edge
  task automatic settle();
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R7 reset: outputs held at zero while reset is low
    clearCfg();
    pTerms = '1;
    setOut(0, 0, 7, 1'b0);
    setOut(1, 0, 1, 1'b0);
    repeat (3) @(negedge clk);
    chk(sumOut == '0, "R7 sumOut in reset", sumOut, 0);
    chk(cfgError == 1'b0, "R7 cfgError in reset", cfgError, 0);
    rstN = 1'b1;
    clearCfg();
    settle();

    // Table walk
    for (int i = 0; i < 16; i++) begin
      logic [NC-1:0] expVec;
      clearCfg();
      setOut(int'(VECS[i].outIdx), int'(VECS[i].start), int'(VECS[i].cnt), VECS[i].byp);
      pTerms[VECS[i].hot] = 1'b1;
      expVec = '0;
      expVec[VECS[i].outIdx] = VECS[i].expBit;
      settle();
      chk(sumOut == expVec, $sformatf("R%0d vector %0d", VECS[i].req, i), sumOut, expVec);
      chk(cfgError == 1'b0, $sformatf("R6 no conflict vector %0d", i), cfgError, 0);
    end

    // R7 latency: new inputs do not show before the next rising edge
    clearCfg();
    settle();
    setOut(2, 2, 1, 1'b0);
    pTerms[10] = 1'b1;
    #1;
    chk(sumOut == '0, "R7 before edge", sumOut, 0);
    settle();
    chk(sumOut == 32'h4, "R7 after edge", sumOut, 32'h4);

    // R6 conflicts: run overlaps a bypass, and an overlap made only by wrap
    clearCfg();
    setOut(0, 0, 2, 1'b0);
    setOut(1, 0, 0, 1'b1);
    settle();
    chk(cfgError == 1'b1, "R6 run over bypass", cfgError, 1);
    clearCfg();
    setOut(5, 31, 2, 1'b0);
    setOut(0, 0, 1, 1'b0);
    settle();
    chk(cfgError == 1'b1, "R6 wrap overlap", cfgError, 1);
    clearCfg();
    setOut(5, 31, 1, 1'b0);
    setOut(0, 0, 1, 1'b0);
    settle();
    chk(cfgError == 1'b0, "R6 adjacent no overlap", cfgError, 0);

    // R1 R2 R4 R8 random legal configurations covering the ring
    for (int t = 0; t < 60; t++) begin
      logic [NC-1:0] used;
      logic [NC-1:0] expVec;
      int base;
      int pos;
      clearCfg();
      used = '0;
      for (int o = 0; o < NC; o++) cfgStart[o*5 +: 5] = 5'($urandom);
      base = int'($urandom % NC);
      pos = 0;
      while (pos < NC) begin
        int len;
        int cl;
        len = 1 + int'($urandom % 7);
        if (len > NC - pos) len = NC - pos;
        cl = (base + pos) % NC;
        if ($urandom % 4 != 0) begin
          if (len == 1 && !used[cl] && ($urandom % 2 == 1)) begin
            used[cl] = 1'b1;
            setOut(cl, int'($urandom % NC), int'($urandom % 8), 1'b1);
          end else begin
            int o;
            o = int'($urandom % NC);
            while (used[o]) o = (o + 1) % NC;
            used[o] = 1'b1;
            setOut(o, cl, len, 1'b0);
          end
        end
        pos += len;
      end
      pTerms = {$urandom, $urandom, $urandom, $urandom, $urandom};
      for (int b = 0; b < NC * TPC; b++) if ($urandom % 3 != 0) pTerms[b] = 1'b0;
      expVec = modelSum(pTerms, cfgStart, cfgCount, cfgBypass);
      settle();
      chk(sumOut == expVec, $sformatf("R1 R2 R8 random %0d", t), sumOut, expVec);
      chk(cfgError == 1'b0, $sformatf("R6 random legal %0d", t), cfgError, 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule